// File: doc/BRIEF.md
# Start-Bit Framed Serial Output Latch

This block converts a two-wire serial stream, a data line and a shift clock, into a bank of parallel on/off outputs. There is no load strobe. Each frame opens with a marker bit of value 1, followed by the data bits. When the marker reaches the far end of the shift chain, the data bits are copied into the output register. The chain is then wiped on the next low phase of the serial clock, so the next frame can follow at once.

The serial clock and data are asynchronous to the system clock. Both are resynchronised through a flop chain, and the serial clock is edge-detected. The system clock must run at least 8 times faster than the serial clock. Each serial clock phase must last at least 4 system cycles.

A build-time option adds a data-enable qualifier. With it, a serial rising edge shifts only while the enable is high, and the highest output is held off.

Top module: `sfl_serial_latch`

## Requirements
- R1: While `rst_n` is low, and after it rises, every output bit is 0 and every shift stage is 0. The first complete frame after reset is latched correctly.
- R2: A frame is one bit of value 1 followed by NUM_OUT data bits, shifted on serial rising edges. The k-th data bit after the marker (k = 1..NUM_OUT) drives `out_o[k-1]`. A 1 turns that output on and a 0 turns it off.
- R3: The outputs change only through a single-cycle load. The load happens once per complete frame, after the marker reaches the last stage on the (NUM_OUT+1)-th rising edge. Between loads the outputs hold.
- R4: After a load, the next serial falling edge clears every shift stage. No bit of the old frame can then reach the last stage early during the next frame.
- R5: Frames may follow each other with no idle clock between them, and each one is latched.
- R6: If a frame stops after fewer than NUM_OUT+1 rising edges, the outputs keep the last latched frame.
- R7: Zero bits clocked in before a marker do not disturb framing. They pass through and the following frame latches correctly.
- R8: With USE_ENABLE=1, a serial rising edge while `ser_en_i` is low shifts nothing.
- R9: With USE_ENABLE=1, `out_o[NUM_OUT-1]` stays 0 whatever the last data bit of the frame is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst_n | input | 1 | Active-low reset of chain, sequencing and outputs |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data, sampled on serial rising edges |
| ser_en_i | input | 1 | Shift qualifier, used only when USE_ENABLE=1 |
| out_o | output | NUM_OUT | Parallel outputs, bit k-1 carries data bit k |

## Verification
A stage that failed to clear would let stale ones reach the last stage within one or two bits of the next frame. The bench catches this by sampling the outputs just two bits into a frame that follows an all-ones frame. A wrong bit order or a shifted mapping shows at the first latch of a walking-one frame, at the mismatching output position. A load that fires too early or too late shows either as outputs changing partway through a frame or as outputs left stale after a full frame. Both are sampled a few system cycles after the relevant serial edge.

// File: rtl/sfl_pkg.sv
`timescale 1ns/1ps
package sfl_pkg;

  // Events decoded from the resynchronised serial clock.
  typedef struct packed {
    logic rise;
    logic fall;
  } sfl_edge_t;

  // Shift stage that holds the data bit driving output index out_idx.
  // The first data bit after the marker sits next to the marker at the
  // far end of the chain, so the order is reversed.
  function automatic int unsigned stage_for_output(input int unsigned out_idx,
                                                   input int unsigned n_out);
    return n_out - 1 - out_idx;
  endfunction

endpackage

// File: rtl/sfl_sync_edge.sv
`timescale 1ns/1ps
module sfl_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_clk_i,
  input  logic             a_dat_i,
  input  logic             a_en_i,
  output sfl_pkg::sfl_edge_t evt_o,
  output logic             dat_o,
  output logic             en_o
);
  localparam int unsigned LAST = STAGES - 1;

  // Bit 0 carries the serial clock, bit 1 the data, bit 2 the enable.
  logic [2:0] stg_q [STAGES];
  logic       clk_prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= {a_en_i, a_dat_i, a_clk_i};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev_q <= 1'b0;
    else        clk_prev_q <= stg_q[LAST][0];
  end

  assign evt_o.rise = stg_q[LAST][0] & ~clk_prev_q;
  assign evt_o.fall = ~stg_q[LAST][0] & clk_prev_q;
  assign dat_o      = stg_q[LAST][1];
  assign en_o       = stg_q[LAST][2];
endmodule

// File: rtl/sfl_shift_chain.sv
`timescale 1ns/1ps
module sfl_shift_chain #(
  parameter int unsigned LEN = 36
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_i,
  input  logic           clear_i,
  input  logic           din_i,
  output logic [LEN-1:0] chain_o
);
  // Stage 0 takes the newest bit; stage LEN-1 is the far end.
  // The input sample itself lives in the synchroniser and is never wiped.
  logic [LEN-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chain_q <= '0;
    else if (shift_i) chain_q <= {chain_q[LEN-2:0], din_i};
    else if (clear_i) chain_q <= '0;
  end

  assign chain_o = chain_q;
endmodule

// File: rtl/sfl_frame_ctrl.sv
`timescale 1ns/1ps
module sfl_frame_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tail_i,
  input  logic fall_i,
  output logic load_o,
  output logic clear_o,
  output logic pend_o
);
  // pend_q: frame latched, chain wipe waiting for the serial low phase.
  logic pend_q;

  assign load_o  = tail_i & ~pend_q;
  assign clear_o = pend_q & fall_i;
  assign pend_o  = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (load_o)  pend_q <= 1'b1;
    else if (clear_o) pend_q <= 1'b0;
  end
endmodule

// File: rtl/sfl_out_latch.sv
`timescale 1ns/1ps
module sfl_out_latch #(
  parameter int unsigned N        = 35,
  parameter bit          DROP_TOP = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [N-1:0] data_i,
  output logic [N-1:0] out_o
);
  logic [N-1:0] mapped;
  logic [N-1:0] out_q;

  for (genvar j = 0; j < N; j++) begin : g_map
    if (DROP_TOP && (j == N - 1)) begin : g_off
      assign mapped[j] = 1'b0;
    end else begin : g_on
      assign mapped[j] = data_i[sfl_pkg::stage_for_output(j, N)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (load_i) out_q <= mapped;
  end

  assign out_o = out_q;
endmodule

// File: rtl/sfl_serial_latch.sv
`timescale 1ns/1ps
module sfl_serial_latch #(
  parameter int unsigned NUM_OUT     = 35,
  parameter bit          USE_ENABLE  = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk_i,
  input  logic               ser_dat_i,
  input  logic               ser_en_i,
  output logic [NUM_OUT-1:0] out_o
);
  localparam int unsigned LEN = NUM_OUT + 1;

  sfl_pkg::sfl_edge_t evt;
  logic           dat_s;
  logic           en_s;
  logic           shift_evt;
  logic           fall_evt;
  logic           load;
  logic           clear;
  logic           pend;
  logic [LEN-1:0] chain;

  sfl_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_clk_i (ser_clk_i),
    .a_dat_i (ser_dat_i),
    .a_en_i  (ser_en_i),
    .evt_o   (evt),
    .dat_o   (dat_s),
    .en_o    (en_s)
  );

  if (USE_ENABLE) begin : g_gated
    assign shift_evt = evt.rise & en_s;
  end else begin : g_free
    assign shift_evt = evt.rise | (en_s & 1'b0);
  end
  assign fall_evt = evt.fall;

  sfl_shift_chain #(.LEN(LEN)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (shift_evt),
    .clear_i (clear),
    .din_i   (dat_s),
    .chain_o (chain)
  );

  sfl_frame_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .tail_i  (chain[LEN-1]),
    .fall_i  (fall_evt),
    .load_o  (load),
    .clear_o (clear),
    .pend_o  (pend)
  );

  sfl_out_latch #(.N(NUM_OUT), .DROP_TOP(USE_ENABLE)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .data_i (chain[NUM_OUT-1:0]),
    .out_o  (out_o)
  );
endmodule

// File: rtl/sfl_serial_latch_chk.sv
`timescale 1ns/1ps
module sfl_serial_latch_chk #(
  parameter int unsigned LEN = 36,
  parameter int unsigned N   = 35
) (
  input logic           clk,
  input logic           rst_n,
  input logic           shift_evt,
  input logic           fall_evt,
  input logic           load,
  input logic           clear,
  input logic           pend,
  input logic [LEN-1:0] chain,
  input logic [N-1:0]   out_o
);
  p_out_only_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_o) |-> $past(load));

  p_load_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load);

  p_clear_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (chain == '0));

  p_pend_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && fall_evt) |=> !pend);

  p_hold_without_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_evt && !clear) |=> $stable(chain));
endmodule

bind sfl_serial_latch sfl_serial_latch_chk #(.LEN(NUM_OUT + 1), .N(NUM_OUT)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .shift_evt (shift_evt),
  .fall_evt  (fall_evt),
  .load      (load),
  .clear     (clear),
  .pend      (pend),
  .chain     (chain),
  .out_o     (out_o)
);

// File: tb/sfl_serial_latch_tb.sv
`timescale 1ns/1ps
module sfl_serial_latch_tb_top;
  localparam int N = 35;
  localparam int HALF = 8;  // system cycles per serial phase

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_a = 0, sdat_a = 0;
  logic sclk_b = 0, sdat_b = 0, sen_b = 0;
  logic [N-1:0] out_a, out_b;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sfl_serial_latch #(.NUM_OUT(N), .USE_ENABLE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk_a), .ser_dat_i(sdat_a),
    .ser_en_i(1'b1), .out_o(out_a));

  sfl_serial_latch #(.NUM_OUT(N), .USE_ENABLE(1'b1)) dut_en_i (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk_b), .ser_dat_i(sdat_b),
    .ser_en_i(sen_b), .out_o(out_b));

  localparam logic [N-1:0] TOP_MASK = ~({{(N-1){1'b0}}, 1'b1} << (N - 1));

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One serial bit: data set during the low phase, then a high phase.
  task automatic sbit(input bit w, input logic d, input logic en);
    @(negedge clk);
    if (w) begin sdat_b = d; sen_b = en; end else sdat_a = d;
    repeat (HALF) @(negedge clk);
    if (w) sclk_b = 1'b1; else sclk_a = 1'b1;
    repeat (HALF) @(negedge clk);
    if (w) sclk_b = 1'b0; else sclk_a = 1'b0;
  endtask

  task automatic frame(input bit w, input logic [N-1:0] d);
    sbit(w, 1'b1, 1'b1);
    for (int k = 0; k < N; k++) sbit(w, d[k], 1'b1);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #750000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [N-1:0] p;
    logic [N-1:0] prev;
    repeat (4) @(negedge clk);
    check("R1 reset a", out_a, '0);
    check("R1 reset b", out_b, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", out_a, '0);

    // R2/R5: walking one and walking zero, back to back, no idle clocks
    for (int i = 0; i < N; i++) begin
      p = '0; p[i] = 1'b1;
      frame(0, p); settle();
      check("R2 walking one", out_a, p);
    end
    for (int i = 0; i < N; i += 3) begin
      p = '1; p[i] = 1'b0;
      frame(0, p); settle();
      check("R5 walking zero", out_a, p);
    end
    p = 35'h5_2A7C_19E3;
    for (int i = 0; i < 8; i++) begin
      p = {p[N-2:0], p[N-1] ^ p[N-3]} ^ (p >> 5);
      frame(0, p); settle();
      check("R2 mixed pattern", out_a, p);
    end

    // R4: after an all-ones frame, a fresh frame must not latch early
    frame(0, '1); settle();
    check("R4 all ones", out_a, '1);
    sbit(0, 1'b1, 1'b1); sbit(0, 1'b0, 1'b1); settle();
    check("R4 no stale load", out_a, '1);
    for (int k = 1; k < N; k++) sbit(0, 1'b0, 1'b1);
    settle();
    check("R4 frame after clear", out_a, {{(N-1){1'b0}}, 1'b0});

    // R3: partway through a frame the outputs hold the previous frame
    p = 35'h1_F0F0_0F0F;
    frame(0, p); settle();
    prev = p;
    sbit(0, 1'b1, 1'b1);
    for (int k = 0; k < 20; k++) sbit(0, ~prev[k], 1'b1);
    settle();
    check("R3 hold mid frame", out_a, prev);
    for (int k = 20; k < N; k++) sbit(0, ~prev[k], 1'b1);
    settle();
    check("R3 load on last edge", out_a, ~prev);

    // R7: leading zeros ahead of the marker
    for (int k = 0; k < 7; k++) sbit(0, 1'b0, 1'b1);
    p = 35'h0_DEAD_BEEF;
    frame(0, p); settle();
    check("R7 leading zeros", out_a, p);

    // R6: short frame leaves outputs alone; R1: reset then recovery
    sbit(0, 1'b1, 1'b1);
    for (int k = 0; k < 17; k++) sbit(0, 1'b1, 1'b1);
    settle();
    check("R6 partial frame", out_a, p);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset clears latch", out_a, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    p = 35'h2_3456_789A;
    frame(0, p); settle();
    check("R1 first frame after reset", out_a, p);

    // R8/R9: enable variant, junk edges with enable low between bits
    for (int t = 0; t < 4; t++) begin
      p = (t == 0) ? '1 : (35'h4_1234_5678 ^ (35'(t) * 35'h0_9E37_79B9));
      sbit(1, 1'b1, 1'b1);
      sbit(1, 1'b1, 1'b0);
      for (int k = 0; k < N; k++) begin
        sbit(1, p[k], 1'b1);
        if (k % 5 == 2) sbit(1, ~p[k], 1'b0);
      end
      settle();
      check("R8 gated shifting", out_b, p & TOP_MASK);
      check("R9 top output held off", {{(N-1){1'b0}}, out_b[N-1]}, '0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule